// File: doc/BRIEF.md
# Interrupt Control and Status Register

This block is the byte-wide interrupt control register of a small microcontroller core. It holds a master enable bit, four per-source enable bits and three sticky event flags, all in one byte that the CPU reads and writes through its register bus. The byte appears at two addresses, so the CPU reaches it from either register bank. The block takes the timer overflow, the external edge event and the A/D-done flag from other blocks, and it watches four port pins for a change. It drives one interrupt request line to the CPU.

An event flag latches when its event happens, whatever the enable bits hold. Only a software write clears a flag. The port-change flag compares the four watched pins against a snapshot that is refreshed each time the CPU reads the port data register. The A/D source keeps its flag outside this register: only its enable bit is here. Interrupt entry clears the master enable and interrupt return sets it again. Each of these takes effect on the same clock edge as its pulse.

Top module: `irq_ctrl_reg`

## Requirements
- R1: After a synchronous reset the register reads 0x00 and `irq_req` is 0.
- R2: The register is written and read at address 0x0B and at address 0x8B, with the same effect at both. A write to any other address changes nothing. A read from any other address, or with `bus_rd` low, returns 0x00.
- R3: The bit layout is fixed because the CPU decodes it. Bit 7 is the master enable. Bit 6 is the A/D enable, bit 5 the timer enable, bit 4 the external enable and bit 3 the port-change enable. Bit 2 is the timer flag, bit 1 the external flag and bit 0 the port-change flag. A write loads all eight bits.
- R4: A `tmr_ovf` pulse sets bit 2 and an `ext_evt` pulse sets bit 1 on the next edge. This happens whatever the enable bits and the master enable hold.
- R5: A flag that is set stays set until a bus write puts a 0 in its position. Writing a 1 to a flag position sets that flag.
- R6: If a flag's set event and a bus write of 0 to that flag fall in the same cycle, the flag ends up set.
- R7: Bit 0 is set on every edge where `port_hi_pins` differs from the snapshot. The snapshot takes the pin values at reset and at every edge where `port_data_rd` is high. The comparison in that cycle uses the old snapshot.
- R8: `irq_req` is high exactly when bit 7 is 1 and at least one of these pairs is 1: (bit 5, bit 2), (bit 4, bit 1), (bit 3, bit 0), (bit 6, `adc_done`).
- R9: `irq_accept` clears bit 7 on the next edge and `irq_return` sets it. Accept has priority over return and over any write, and return has priority over a write.
- R10: `adc_done` affects only `irq_req`. It never appears in the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | Register bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, 0 when not selected |
| port_data_rd | input | 1 | CPU is reading the port data register |
| port_hi_pins | input | 4 | The four watched port pins |
| tmr_ovf | input | 1 | Timer overflow pulse |
| ext_evt | input | 1 | External edge event pulse |
| adc_done | input | 1 | A/D conversion complete flag (held elsewhere) |
| irq_accept | input | 1 | Interrupt entry pulse |
| irq_return | input | 1 | Return-from-interrupt pulse |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
All state is visible through a read, and the bench compares the read value and `irq_req` with a reference model on every clock. A wrong bit therefore appears at the ports on the first edge after its cause. A stale port snapshot shows up later: bit 0 sets again after software has cleared it. A wrong priority between master-enable updates shows as an `irq_req` that is high, or low, one cycle after an entry or return pulse when it should not be.

// File: rtl/irq_ctrl_pkg.sv
// Package: bit positions of the interrupt control byte and sizes shared by
// the register, its helpers and its checker. Positions are fixed because the
// CPU software decodes them.
package irq_ctrl_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_FLAGS = 3;
    localparam int NUM_EN    = 4;

    localparam int POS_GIE   = 7;   // master enable
    localparam int POS_ADIE  = 6;   // A/D enable
    localparam int POS_TIE   = 5;   // timer enable
    localparam int POS_XIE   = 4;   // external enable
    localparam int POS_PIE   = 3;   // port-change enable
    localparam int POS_TF    = 2;   // timer flag
    localparam int POS_XF    = 1;   // external flag
    localparam int POS_PF    = 0;   // port-change flag

    localparam int EN_LSB    = POS_PIE;
    localparam int EN_MSB    = POS_ADIE;
endpackage

// File: rtl/irq_addr_match.sv
// Module: irq_addr_match
// Decodes the register bus for one register that answers at two mirrored
// addresses. Assumes strobes are single-cycle qualified by the bus master.
module irq_addr_match #(
    parameter int             ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 8'h0B,
    parameter logic [ADDR_W-1:0] MIRROR = 8'h8B
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_hit,
    output logic              rd_hit
);
    logic sel;

    // Address match at either mirrored location
    always_comb begin
        sel    = (addr == BASE) || (addr == MIRROR);
        wr_hit = wr && sel;
        rd_hit = rd && sel;
    end
endmodule

// File: rtl/irq_port_watch.sv
// Module: irq_port_watch
// Holds a snapshot of the watched port pins and flags any difference from it.
// The snapshot is loaded at reset and whenever the port data register is
// read. Assumes pins are already synchronised to clk.
module irq_port_watch #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic         rd_strobe,
    output logic         change
);
    logic [W-1:0] snap_q;

    // Snapshot register: loaded on reset and on each port read
    always_ff @(posedge clk) begin
        if (!rst_n || rd_strobe) begin
            snap_q <= pins;
        end
    end

    // Mismatch against the snapshot held before this edge
    always_comb begin
        change = |(pins ^ snap_q);
    end
endmodule

// File: rtl/irq_flag_cell.sv
// Module: irq_flag_cell
// One sticky event flag. A hardware set wins over a software write in the
// same cycle; otherwise a write loads the written bit. Never self-clears.
module irq_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic wr_i,
    input  logic wdata_i,
    output logic q_o
);
    // Flag state: reset, hardware set, software load, else hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (set_i) begin
            q_o <= 1'b1;
        end else if (wr_i) begin
            q_o <= wdata_i;
        end
    end
endmodule

// File: rtl/irq_ctrl_reg.sv
// Module: irq_ctrl_reg
// Interrupt control byte: master enable, four source enables, three sticky
// flags, port-change detection and the interrupt request. Assumes all inputs
// are synchronous to clk and event inputs are one-cycle pulses.
module irq_ctrl_reg
    import irq_ctrl_pkg::*;
#(
    parameter int          ADDR_W = 8,
    parameter logic [ADDR_W-1:0] BASE   = 8'h0B,
    parameter logic [ADDR_W-1:0] MIRROR = 8'h8B,
    parameter int          PORT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              port_data_rd,
    input  logic [PORT_W-1:0] port_hi_pins,
    input  logic              tmr_ovf,
    input  logic              ext_evt,
    input  logic              adc_done,
    input  logic              irq_accept,
    input  logic              irq_return,
    output logic              irq_req
);
    logic                 wr_hit;
    logic                 rd_hit;
    logic                 port_change;
    logic [NUM_FLAGS-1:0] flag_set;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_EN-1:0]    en_q;
    logic                 gie_q;
    logic [REG_W-1:0]     ctrl_q;

    irq_addr_match #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE),
        .MIRROR (MIRROR)
    ) u_match (
        .addr   (bus_addr),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit)
    );

    irq_port_watch #(
        .W (PORT_W)
    ) u_watch (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins      (port_hi_pins),
        .rd_strobe (port_data_rd),
        .change    (port_change)
    );

    // Set sources in flag-position order
    always_comb begin
        flag_set         = '0;
        flag_set[POS_TF] = tmr_ovf;
        flag_set[POS_XF] = ext_evt;
        flag_set[POS_PF] = port_change;
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        irq_flag_cell u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (flag_set[i]),
            .wr_i    (wr_hit),
            .wdata_i (bus_wdata[i]),
            .q_o     (flag_q[i])
        );
    end

    // Source enables: plain software-written bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_hit) begin
            en_q <= bus_wdata[EN_MSB:EN_LSB];
        end
    end

    // Master enable: accept beats return beats software write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gie_q <= 1'b0;
        end else if (irq_accept) begin
            gie_q <= 1'b0;
        end else if (irq_return) begin
            gie_q <= 1'b1;
        end else if (wr_hit) begin
            gie_q <= bus_wdata[POS_GIE];
        end
    end

    // Assemble the architectural byte
    always_comb begin
        ctrl_q = {gie_q, en_q, flag_q};
    end

    // Read mux: zero unless this register is selected
    always_comb begin
        bus_rdata = rd_hit ? ctrl_q : '0;
    end

    // Request: master enable over the OR of enabled sources
    always_comb begin
        irq_req = ctrl_q[POS_GIE] &&
                  ((ctrl_q[POS_TIE]  && ctrl_q[POS_TF]) ||
                   (ctrl_q[POS_XIE]  && ctrl_q[POS_XF]) ||
                   (ctrl_q[POS_PIE]  && ctrl_q[POS_PF]) ||
                   (ctrl_q[POS_ADIE] && adc_done));
    end
endmodule

// File: rtl/irq_ctrl_reg_chk.sv
// Module: irq_ctrl_reg_chk
// Property checker for irq_ctrl_reg, attached with bind below.
module irq_ctrl_reg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_accept,
    input logic       irq_return,
    input logic       tmr_ovf,
    input logic       ext_evt,
    input logic       wr_hit,
    input logic [7:0] ctrl_q,
    input logic       irq_req
);
    AST_ACCEPT_CLEARS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_accept |=> !ctrl_q[7]); // R9
    AST_RETURN_SETS_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_accept) |=> ctrl_q[7]); // R9
    AST_TMR_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_ovf |=> ctrl_q[2]); // R4
    AST_EXT_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ext_evt |=> ctrl_q[1]); // R4
    AST_TMR_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[2] && !wr_hit) |=> ctrl_q[2]); // R5
    AST_EXT_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_evt && wr_hit) |=> ctrl_q[1]); // R6
    AST_NO_REQ_WITHOUT_GIE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[7] |-> !irq_req); // R8
endmodule

bind irq_ctrl_reg irq_ctrl_reg_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_accept (irq_accept),
    .irq_return (irq_return),
    .tmr_ovf    (tmr_ovf),
    .ext_evt    (ext_evt),
    .wr_hit     (wr_hit),
    .ctrl_q     (ctrl_q),
    .irq_req    (irq_req)
);

// File: tb/irq_ctrl_reg_tb.sv
// Bench: behavioural reference model updated at each rising edge, outputs
// compared at the following falling edge.
module irq_ctrl_reg_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       port_data_rd = 1'b0;
    logic [3:0] port_hi_pins = 4'h0;
    logic       tmr_ovf = 1'b0;
    logic       ext_evt = 1'b0;
    logic       adc_done = 1'b0;
    logic       irq_accept = 1'b0;
    logic       irq_return = 1'b0;
    logic       irq_req;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit [7:0] m_reg;
    bit [3:0] m_snap;

    always #10 clk = ~clk;

    irq_ctrl_reg u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .port_data_rd(port_data_rd), .port_hi_pins(port_hi_pins),
        .tmr_ovf(tmr_ovf), .ext_evt(ext_evt), .adc_done(adc_done),
        .irq_accept(irq_accept), .irq_return(irq_return), .irq_req(irq_req)
    );

    function automatic bit sel(input logic [7:0] a);
        return (a == 8'h0B) || (a == 8'h8B);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        bit [7:0] nxt;
        if (!rst_n) begin
            m_reg  = 8'h00;
            m_snap = port_hi_pins;
        end else begin
            nxt = m_reg;
            if (bus_wr && sel(bus_addr)) nxt = bus_wdata;
            if (tmr_ovf) nxt[2] = 1'b1;
            if (ext_evt) nxt[1] = 1'b1;
            if (port_hi_pins != m_snap) nxt[0] = 1'b1;
            if (irq_accept) nxt[7] = 1'b0;
            else if (irq_return) nxt[7] = 1'b1;
            m_reg = nxt;
            if (port_data_rd) m_snap = port_hi_pins;
        end
    endtask

    // One clock: model follows the edge, then outputs are compared
    task automatic tick(input string req);
        bit exp_irq;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        exp_irq = m_reg[7] && ((m_reg[5] && m_reg[2]) || (m_reg[4] && m_reg[1]) ||
                               (m_reg[3] && m_reg[0]) || (m_reg[6] && adc_done));
        check(req, bus_rdata, (bus_rd && sel(bus_addr)) ? m_reg : 8'h00);
        check({req, " irq"}, {7'd0, irq_req}, {7'd0, exp_irq});
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; tmr_ovf = 0; ext_evt = 0;
        irq_accept = 0; irq_return = 0; port_data_rd = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string req);
        bus_addr = a; bus_wdata = d; bus_wr = 1; tick(req); idle();
    endtask

    // Read with an explicit constant expectation as well as the model
    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        bus_addr = a; bus_rd = 1; tick(req);
        check(req, bus_rdata, exp);
        idle();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        port_hi_pins = 4'h5;
        repeat (3) tick("R1 reset");
        rst_n = 1;
        rd(8'h0B, 8'h00, "R1 after reset");

        // R2 and R3: both addresses, layout via readback
        wr(8'h0B, 8'h78, "R2 write base");
        rd(8'h8B, 8'h78, "R2 read mirror");
        wr(8'h8B, 8'h00, "R2 write mirror");
        rd(8'h0B, 8'h00, "R3 cleared");
        wr(8'h0C, 8'hFF, "R2 stray write");
        rd(8'h0B, 8'h00, "R2 stray ignored");
        rd(8'h0C, 8'h00, "R2 stray read");

        // R4: flags latch with all enables off
        tmr_ovf = 1; tick("R4 timer"); idle();
        ext_evt = 1; tick("R4 external"); idle();
        rd(8'h0B, 8'h06, "R4 both flags");
        repeat (4) tick("R5 hold");
        rd(8'h0B, 8'h06, "R5 sticky");

        // R8: master plus timer enable raises request
        wr(8'h0B, 8'hA6, "R8 enable timer");
        rd(8'h0B, 8'hA6, "R8 readback");
        wr(8'h0B, 8'h20 | 8'h02, "R8 master off");
        wr(8'h0B, 8'h90 | 8'h02, "R8 external");
        wr(8'h0B, 8'h80, "R5 clear flags");
        rd(8'h0B, 8'h80, "R5 flags zero");

        // R10: A/D source through its enable only
        wr(8'h0B, 8'hC0, "R10 enable adc");
        adc_done = 1; tick("R10 adc high");
        rd(8'h0B, 8'hC0, "R10 not in reg");
        adc_done = 0; tick("R10 adc low");

        // R6: set wins over clearing write
        wr(8'h0B, 8'h04, "R5 write one sets");
        bus_addr = 8'h0B; bus_wdata = 8'h00; bus_wr = 1; tmr_ovf = 1;
        tick("R6 collide"); idle();
        rd(8'h0B, 8'h04, "R6 set wins");
        wr(8'h0B, 8'h00, "R6 clear");

        // R7: port change, clear without and with a port read
        port_hi_pins = 4'h6; tick("R7 change");
        rd(8'h0B, 8'h01, "R7 flag set");
        wr(8'h0B, 8'h00, "R7 clear no read");
        rd(8'h0B, 8'h01, "R7 flag returns");
        port_data_rd = 1; tick("R7 port read"); idle();
        wr(8'h0B, 8'h08, "R7 clear after read");
        rd(8'h0B, 8'h08, "R7 stays clear");
        port_hi_pins = 4'hE; tick("R7 second change");
        rd(8'h0B, 8'h09, "R7 flag and enable");
        wr(8'h0B, 8'h89, "R8 port request");
        port_data_rd = 1; tick("R7 read"); idle();
        wr(8'h0B, 8'h88, "R7 clear");

        // R9: entry/return and priorities
        wr(8'h0B, 8'hA4, "R9 arm");
        irq_accept = 1; tick("R9 accept"); idle();
        rd(8'h0B, 8'h24, "R9 gie cleared");
        irq_return = 1; tick("R9 return"); idle();
        rd(8'h0B, 8'hA4, "R9 gie set");
        bus_addr = 8'h0B; bus_wdata = 8'hA4; bus_wr = 1; irq_accept = 1;
        tick("R9 accept over write"); idle();
        rd(8'h0B, 8'h24, "R9 accept wins");
        irq_accept = 1; irq_return = 1; tick("R9 accept over return"); idle();
        rd(8'h0B, 8'h24, "R9 still clear");
        bus_addr = 8'h8B; bus_wdata = 8'h24; bus_wr = 1; irq_return = 1;
        tick("R9 return over write"); idle();
        rd(8'h0B, 8'hA4, "R9 return wins");

        // R1: reset mid-run
        rst_n = 0; tick("R1 reset again"); rst_n = 1;
        rd(8'h8B, 8'h00, "R1 cleared");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule